// File: doc/BRIEF.md
# Partially Banked General-Purpose Register File

This block holds a processor's sixteen 32-bit general-purpose registers. Only the low eight names, r0 to r7, have two physical copies. The upper eight, r8 to r15, exist once and are shared. A bank-select bit picks which copy of r0 to r7 the ordinary register names reach. The block keeps that bit internally and loads it through a small status-write strobe, so the rest of the status register stays outside.

Normal operand traffic uses two combinational read ports and one write port, all addressed with 4-bit names. A separate alternate port, addressed with 3-bit indices, reads or writes the copy of r0 to r7 that is *not* currently selected, in the way control-register move instructions would. Trap handlers can therefore use the other bank as scratch space without disturbing the live bank. The alternate port only works in privileged mode. In user mode an attempt raises an illegal-access flag and changes nothing.

A read of a register that is being written in the same cycle returns the new value. This write-first rule holds on both the normal ports and the alternate port.

Top module: `bank_rf`

## Requirements
- R1: After a synchronous active-low reset, every register of both banks reads zero and `bank_sel_q` is 0 (bank 0 selected).
- R2: Registers r8 to r15 have a single copy: a value written while either bank is selected reads back unchanged under the other selection.
- R3: Registers r0 to r7 are banked: a write under bank 0 is not visible under bank 1, and the reverse also holds.
- R4: When `bank_sel_we` loads `bank_sel_d`, reads in that same cycle still use the old bank. `bank_sel_q` and all reads switch to the new bank from the next cycle.
- R5: In privileged mode (`priv`=1), the alternate port reads and writes `alt_idx` in the bank opposite `bank_sel_q`, and the active bank is left unchanged.
- R6: Read ports A and B return two different registers independently in the same cycle.
- R7: A normal read whose index matches a normal write in the same cycle returns `wr_data` in that cycle.
- R8: A privileged alternate read and alternate write to the same `alt_idx` in one cycle return `alt_wr_data` on `alt_rd_data`.
- R9: With `priv`=0, any alternate read or write drives `illegal`=1 in the same cycle, stores nothing, and returns 0 on `alt_rd_data`.
- R10: `illegal` is 0 whenever `priv`=1 or no alternate access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel_we | input | 1 | Load strobe for the bank-select bit |
| bank_sel_d | input | 1 | New bank-select value |
| bank_sel_q | output | 1 | Current bank-select bit |
| priv | input | 1 | 1 = privileged mode, 0 = user mode |
| rd_a_idx | input | 4 | Read port A register name |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register name |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write register name |
| wr_data | input | 32 | Normal write data |
| alt_rd_en | input | 1 | Alternate-bank read request |
| alt_wr_en | input | 1 | Alternate-bank write request |
| alt_idx | input | 3 | Alternate-bank register index (0 to 7) |
| alt_wr_data | input | 32 | Alternate-bank write data |
| alt_rd_data | output | 32 | Alternate-bank read data (0 when blocked or idle) |
| illegal | output | 1 | User-mode alternate access attempted |

## Verification
The read data, `alt_rd_data` and `illegal` are combinational. They are due in the cycle the stimulus is applied, so the bench changes inputs on the falling edge and samples them 1 ns later. Stored writes and bank-select changes take effect one rising edge later. Checks of those results are therefore made after the next falling edge, and the cycle of the strobe itself is checked separately to confirm that the old bank is still in use.

// File: rtl/bank_rf_pkg.sv
// Package: shared sizing for the banked register file.
// Assumes the banked names are the lowest BANKED indices of the file.
package bank_rf_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NREG   = 16;
    localparam int unsigned BANKED = 8;
endpackage

// File: rtl/bank_rf_map.sv
// Module: converts an architectural register name plus bank selection
// into a physical slot. Layout: bank0 copies in slots [0, BANKED),
// bank1 copies in [BANKED, 2*BANKED), shared names above those.
// Assumes NREG > BANKED.
module bank_rf_map #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned BANKED = 8,
    localparam int unsigned IW    = $clog2(NREG),
    localparam int unsigned PW    = $clog2(NREG + BANKED)
) (
    input  logic [IW-1:0] idx,
    input  logic          sel,
    output logic [PW-1:0] phys
);
    localparam logic [PW-1:0] OFS = PW'(BANKED);

    // Banked names are offset by the selection; shared names move above both banks.
    always_comb begin
        if (PW'(idx) < OFS) phys = sel ? PW'(idx) + OFS : PW'(idx);
        else                phys = PW'(idx) + OFS;
    end
endmodule

// File: rtl/bank_rf_store.sv
// Module: physical storage with NW write ports and NR read ports.
// Reads are combinational with write-first forwarding: a read of a slot
// being written this cycle returns the incoming data.
// Assumes the write ports never target the same slot in one cycle.
module bank_rf_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOTS  = 24,
    parameter int unsigned NW     = 2,
    parameter int unsigned NR     = 3,
    localparam int unsigned PW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we    [NW],
    input  logic [PW-1:0]     waddr [NW],
    input  logic [DATA_W-1:0] wdata [NW],
    input  logic [PW-1:0]     raddr [NR],
    output logic [DATA_W-1:0] rdata [NR]
);
    logic [DATA_W-1:0] mem [SLOTS];

    // Clear all slots on reset, otherwise apply each enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SLOTS); i++) mem[i] <= '0;
        end else begin
            for (int w = 0; w < int'(NW); w++)
                if (we[w]) mem[waddr[w]] <= wdata[w];
        end
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        // Stored value unless a same-cycle write to this slot is pending.
        always_comb begin
            rdata[r] = mem[raddr[r]];
            for (int w = 0; w < int'(NW); w++)
                if (we[w] && waddr[w] == raddr[r]) rdata[r] = wdata[w];
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_wchk
        // R2, R3, R5: an accepted write is held in its slot on the next cycle
        write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we[w] |=> mem[$past(waddr[w])] == $past(wdata[w]));
    end

    // R5: the two write ports never collide on one slot
    no_port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] && we[1]) |-> waddr[0] != waddr[1]);
endmodule

// File: rtl/bank_rf.sv
// Module: top of the partially banked register file. Holds the bank-select
// bit, maps the normal ports through the active bank and the alternate port
// to the inactive bank, and blocks the alternate port outside privileged mode.
// Assumes priv is valid whenever an alternate request is raised.
module bank_rf
    import bank_rf_pkg::*;
#(
    localparam int unsigned IW = $clog2(NREG),
    localparam int unsigned AW = $clog2(BANKED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel_we,
    input  logic              bank_sel_d,
    output logic              bank_sel_q,
    input  logic              priv,
    input  logic [IW-1:0]     rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IW-1:0]     rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alt_rd_en,
    input  logic              alt_wr_en,
    input  logic [AW-1:0]     alt_idx,
    input  logic [DATA_W-1:0] alt_wr_data,
    output logic [DATA_W-1:0] alt_rd_data,
    output logic              illegal
);
    localparam int unsigned SLOTS = NREG + BANKED;
    localparam int unsigned PW    = $clog2(SLOTS);
    localparam int unsigned NMAP  = 3;   // read A, read B, write

    logic              sel_q;
    logic [IW-1:0]     map_idx  [NMAP];
    logic [PW-1:0]     map_phys [NMAP];
    logic [PW-1:0]     alt_phys;
    logic              alt_ok;
    logic              st_we    [2];
    logic [PW-1:0]     st_waddr [2];
    logic [DATA_W-1:0] st_wdata [2];
    logic [PW-1:0]     st_raddr [3];
    logic [DATA_W-1:0] st_rdata [3];

    // Bank-select bit: cleared by reset, loaded by its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           sel_q <= 1'b0;
        else if (bank_sel_we) sel_q <= bank_sel_d;
    end
    assign bank_sel_q = sel_q;

    assign map_idx[0] = rd_a_idx;
    assign map_idx[1] = rd_b_idx;
    assign map_idx[2] = wr_idx;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        bank_rf_map #(.NREG(NREG), .BANKED(BANKED)) u_map (
            .idx  (map_idx[m]),
            .sel  (sel_q),
            .phys (map_phys[m])
        );
    end

    // Alternate index always addresses the bank that is not selected.
    always_comb alt_phys = sel_q ? PW'(alt_idx) : PW'(alt_idx) + PW'(BANKED);

    // Privilege gate and illegal-access flag for the alternate path.
    always_comb begin
        alt_ok  = priv;
        illegal = (alt_rd_en || alt_wr_en) && !priv;
    end

    assign st_we[0]    = wr_en;
    assign st_waddr[0] = map_phys[2];
    assign st_wdata[0] = wr_data;
    assign st_we[1]    = alt_wr_en && alt_ok;
    assign st_waddr[1] = alt_phys;
    assign st_wdata[1] = alt_wr_data;
    assign st_raddr[0] = map_phys[0];
    assign st_raddr[1] = map_phys[1];
    assign st_raddr[2] = alt_phys;

    bank_rf_store #(.DATA_W(DATA_W), .SLOTS(SLOTS), .NW(2), .NR(3)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (st_raddr),
        .rdata (st_rdata)
    );

    assign rd_a_data = st_rdata[0];
    assign rd_b_data = st_rdata[1];

    // Alternate read data is zero unless a permitted read is requested.
    always_comb alt_rd_data = (alt_rd_en && alt_ok) ? st_rdata[2] : '0;

    // R1
    reset_bank0_chk: assert property (@(posedge clk)
        !rst_n |=> !bank_sel_q);
    // R4
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel_we |=> bank_sel_q == $past(bank_sel_d));
    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_sel_we |=> $stable(bank_sel_q));
    // R9
    user_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !priv |-> !st_we[1]);
    // R9
    user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !priv |-> alt_rd_data == '0);
    // R10
    priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv |-> !illegal);
    // R7
    fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_a_idx) |-> rd_a_data == wr_data);
    // R8
    alt_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv && alt_rd_en && alt_wr_en) |-> alt_rd_data == alt_wr_data);
endmodule

// File: tb/tb_bank_rf.sv
// Directed bench: one task per scenario. Inputs change on the falling
// edge; combinational results are sampled 1 ns later.
module tb_bank_rf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel_we = 1'b0, bank_sel_d = 1'b0, priv = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [2:0]  alt_idx = '0;
    logic        wr_en = 1'b0, alt_rd_en = 1'b0, alt_wr_en = 1'b0;
    logic [31:0] wr_data = '0, alt_wr_data = '0;
    logic        bank_sel_q, illegal;
    logic [31:0] rd_a_data, rd_b_data, alt_rd_data;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bank_rf dut (
        .clk(clk), .rst_n(rst_n), .bank_sel_we(bank_sel_we), .bank_sel_d(bank_sel_d),
        .bank_sel_q(bank_sel_q), .priv(priv), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .alt_rd_en(alt_rd_en), .alt_wr_en(alt_wr_en), .alt_idx(alt_idx),
        .alt_wr_data(alt_wr_data), .alt_rd_data(alt_rd_data), .illegal(illegal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_bank(input logic b);
        @(negedge clk); bank_sel_we = 1'b1; bank_sel_d = b;
        @(negedge clk); bank_sel_we = 1'b0;
    endtask

    task automatic rd_a(input logic [3:0] i, output logic [31:0] v);
        @(negedge clk); rd_a_idx = i; #1 v = rd_a_data;
    endtask

    task automatic alt_rd(input logic [2:0] i, output logic [31:0] v);
        @(negedge clk); alt_rd_en = 1'b1; alt_idx = i; #1 v = alt_rd_data;
        @(negedge clk); alt_rd_en = 1'b0;
    endtask

    task automatic t_reset;   // R1
        logic [31:0] v;
        check("R1 bank_sel", 32'(bank_sel_q), 32'd0);
        for (int i = 0; i < 16; i++) begin rd_a(4'(i), v); check("R1 bank0 reg", v, 0); end
        for (int i = 0; i < 8; i++) begin alt_rd(3'(i), v); check("R1 bank1 reg", v, 0); end
    endtask

    task automatic t_banked;  // R3
        logic [31:0] v;
        wr(4'd3, 32'hAAAA_0003);
        set_bank(1'b1);
        rd_a(4'd3, v); check("R3 bank1 r3 untouched", v, 0);
        wr(4'd3, 32'hBBBB_0003);
        set_bank(1'b0);
        rd_a(4'd3, v); check("R3 bank0 r3 kept", v, 32'hAAAA_0003);
    endtask

    task automatic t_shared;  // R2
        logic [31:0] v;
        set_bank(1'b1);
        wr(4'd10, 32'hCCCC_000A);
        set_bank(1'b0);
        rd_a(4'd10, v); check("R2 shared r10", v, 32'hCCCC_000A);
    endtask

    task automatic t_sel_timing;  // R4
        @(negedge clk); rd_a_idx = 4'd3; bank_sel_we = 1'b1; bank_sel_d = 1'b1;
        #1 check("R4 old bank same cycle", rd_a_data, 32'hAAAA_0003);
        @(negedge clk); bank_sel_we = 1'b0;
        #1 check("R4 new bank next cycle", rd_a_data, 32'hBBBB_0003);
        check("R4 bank_sel_q", 32'(bank_sel_q), 32'd1);
        set_bank(1'b0);
    endtask

    task automatic t_alt;  // R5
        logic [31:0] v;
        alt_rd(3'd3, v); check("R5 alt reads bank1", v, 32'hBBBB_0003);
        @(negedge clk); alt_wr_en = 1'b1; alt_idx = 3'd5; alt_wr_data = 32'hDDDD_0005;
        @(negedge clk); alt_wr_en = 1'b0;
        rd_a(4'd5, v); check("R5 active r5 untouched", v, 0);
        set_bank(1'b1);
        rd_a(4'd5, v); check("R5 alt write landed", v, 32'hDDDD_0005);
        alt_rd(3'd3, v); check("R5 alt reads bank0", v, 32'hAAAA_0003);
        set_bank(1'b0);
    endtask

    task automatic t_dual;  // R6
        @(negedge clk); rd_a_idx = 4'd3; rd_b_idx = 4'd10;
        #1 check("R6 port A", rd_a_data, 32'hAAAA_0003);
        check("R6 port B", rd_b_data, 32'hCCCC_000A);
    endtask

    task automatic t_bypass;  // R7
        @(negedge clk); wr_en = 1'b1; wr_idx = 4'd7; wr_data = 32'hEEEE_0007;
        rd_a_idx = 4'd7; rd_b_idx = 4'd7;
        #1 check("R7 fwd A", rd_a_data, 32'hEEEE_0007);
        check("R7 fwd B", rd_b_data, 32'hEEEE_0007);
        @(negedge clk); wr_en = 1'b0;
        #1 check("R7 stored", rd_a_data, 32'hEEEE_0007);
    endtask

    task automatic t_alt_bypass;  // R8
        logic [31:0] v;
        @(negedge clk); alt_rd_en = 1'b1; alt_wr_en = 1'b1; alt_idx = 3'd2;
        alt_wr_data = 32'hFFFF_0002;
        #1 check("R8 alt fwd", alt_rd_data, 32'hFFFF_0002);
        @(negedge clk); alt_wr_en = 1'b0; alt_rd_en = 1'b0;
        alt_rd(3'd2, v); check("R8 alt stored", v, 32'hFFFF_0002);
    endtask

    task automatic t_user;  // R9
        logic [31:0] v;
        @(negedge clk); priv = 1'b0; alt_wr_en = 1'b1; alt_idx = 3'd6; alt_wr_data = 32'h1234_5678;
        #1 check("R9 illegal on write", 32'(illegal), 32'd1);
        @(negedge clk); alt_wr_en = 1'b0; alt_rd_en = 1'b1; alt_idx = 3'd3;
        #1 check("R9 illegal on read", 32'(illegal), 32'd1);
        check("R9 read returns zero", alt_rd_data, 0);
        @(negedge clk); alt_rd_en = 1'b0; priv = 1'b1;
        alt_rd(3'd6, v); check("R9 no write stored", v, 0);
    endtask

    task automatic t_legal;  // R10
        @(negedge clk); priv = 1'b1; alt_rd_en = 1'b1; alt_idx = 3'd0;
        #1 check("R10 priv access legal", 32'(illegal), 32'd0);
        @(negedge clk); alt_rd_en = 1'b0; priv = 1'b0;
        #1 check("R10 idle user legal", 32'(illegal), 32'd0);
        @(negedge clk); priv = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_banked();
        t_shared();
        t_sel_timing();
        t_alt();
        t_dual();
        t_bypass();
        t_alt_bypass();
        t_user();
        t_legal();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule